// File: doc/BRIEF.md
# Outbound Request Window Mapper and Splitter

This block sits between an internal bus master and the transaction layer of a serial link controller. Each outbound request carries a direction flag, a lock flag, a start address and a byte count. The block compares the address with a small bank of programmable translation windows. The lowest-numbered enabled window that matches supplies two things: the kind of link transaction to build (memory, I/O, message or configuration) and the translated address, formed from the window's translation base and the untranslated offset bits of the request.

An accepted request is then cut into chunks. The largest chunk allowed depends on direction. Writes use the payload-size code and reads use the read-request-size code. No chunk ever exceeds 256 bytes, and no chunk crosses a 4 KB address boundary. Chunks leave the block one descriptor at a time over a valid/ready handshake, and the final descriptor is flagged.

Some requests are refused with a one-cycle error pulse and produce no descriptor at all:
- locked requests,
- requests of zero length,
- requests that match no window,
- requests that reach a configuration or I/O window while the controller is in endpoint mode.

Top module: `owm_top`

## Requirements
- R1: Enabled windows are searched from index 0 upward, and the lowest-numbered enabled window whose base and mask match the request address is used. A disabled window never matches. The translated address is `(xlat & mask) | (addr & ~mask)`.
- R2: When no enabled window matches, `err_valid` is high for exactly the cycle after acceptance, and no descriptor is emitted.
- R3: The type codes are 0 = memory, 1 = I/O, 2 = message and 3 = configuration. With `rc_mode` = 0, a hit on an I/O or configuration window gives an error with no descriptors. Memory and message hits are issued in both modes.
- R4: A request with `req_lock` = 1 is rejected with an error, and no descriptors are emitted.
- R5: For writes, each chunk length is at most `min(128 << mps_code, 256)` bytes.
- R6: For reads, each chunk length is at most `min(128 << mrrs_code, 256)` bytes.
- R7: No chunk crosses a 4 KB boundary. An unaligned start gets a shortened first chunk that ends at the next boundary.
- R8: Chunk addresses are contiguous from the translated start. The chunk lengths sum to `req_len`. `d_last` is high only on the final chunk.
- R9: `req_ready` is low from acceptance until the final descriptor is handed off. A descriptor held while `d_ready` is low keeps its address and length unchanged.
- R10: A request with `req_len` = 0 is rejected with an error.
- R11: After reset, `req_ready` = 1, `d_valid` = 0 and `err_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_mode | input | 1 | 1 = root complex, 0 = endpoint |
| mps_code | input | 3 | Write size limit code |
| mrrs_code | input | 3 | Read size limit code |
| win_en | input | NWIN | Per-window enable |
| win_base | input | NWIN*AW | Window base addresses |
| win_mask | input | NWIN*AW | Window compare masks |
| win_xlat | input | NWIN*AW | Window translation bases |
| win_type | input | 2*NWIN | Window transaction type codes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Locked request flag |
| req_addr | input | AW | Request start address |
| req_len | input | LW | Request length in bytes |
| err_valid | output | 1 | One-cycle error response |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Descriptor taken |
| d_write | output | 1 | Descriptor direction |
| d_type | output | 2 | Descriptor transaction type |
| d_addr | output | AW | Chunk translated address |
| d_len | output | 9 | Chunk length in bytes (1 to 256) |
| d_last | output | 1 | Final chunk of the request |

## Verification
The bench builds the block with four windows, 32-bit addresses and a 13-bit length. This allows a single 4096-byte request that splits into sixteen full chunks. Two overlapping windows of different types test the search priority. One request per window type checks the mode gating, and one window is disabled partway through. The length width lets the bench reach both the 256-byte ceiling, using a size code of 7, and the 128-byte floor, using a code of 0, against boundary-crossing starts such as an address one byte below a 4 KB line.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        TT_MEM = 2'd0,
        TT_IO  = 2'd1,
        TT_MSG = 2'd2,
        TT_CFG = 2'd3
    } tt_e;

    localparam int MAX_CHUNK  = 256;
    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_BITS  = 12;
    localparam int CLEN_W     = 9;

    typedef struct packed {
        logic hit;
        tt_e  ttype;
    } match_t;

    // 128 << code, capped at 256: only code 0 stays below the cap
    function automatic logic [CLEN_W-1:0] lim_bytes(input logic [2:0] code);
        return (code == 3'd0) ? 9'd128 : 9'd256;
    endfunction

    function automatic logic type_needs_rc(input tt_e t);
        return (t == TT_IO) || (t == TT_CFG);
    endfunction

endpackage

// File: rtl/owm_win_match.sv
module owm_win_match
    import owm_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 32
) (
    input  logic [AW-1:0]      addr,
    input  logic [NWIN-1:0]    win_en,
    input  logic [NWIN*AW-1:0] win_base,
    input  logic [NWIN*AW-1:0] win_mask,
    input  logic [NWIN*AW-1:0] win_xlat,
    input  logic [2*NWIN-1:0]  win_type,
    output match_t             res,
    output logic [AW-1:0]      xaddr
);

    logic [NWIN-1:0] hitv;
    logic [AW-1:0]   xl [NWIN];

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic [AW-1:0] m;
        assign m       = win_mask[i*AW +: AW];
        assign hitv[i] = win_en[i] && ((addr & m) == (win_base[i*AW +: AW] & m));
        assign xl[i]   = (win_xlat[i*AW +: AW] & m) | (addr & ~m);
    end

    // lowest index wins: scan from the top so lower indices override
    always_comb begin
        res.hit   = 1'b0;
        res.ttype = TT_MEM;
        xaddr     = addr;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                res.hit   = 1'b1;
                res.ttype = tt_e'(win_type[2*i +: 2]);
                xaddr     = xl[i];
            end
        end
    end

endmodule

// File: rtl/owm_admit.sv
module owm_admit
    import owm_pkg::*;
(
    input  logic   req_lock,
    input  logic   len_zero,
    input  match_t m,
    input  logic   rc_mode,
    output logic   ok
);

    logic mode_bad;

    always_comb begin
        mode_bad = !rc_mode && type_needs_rc(m.ttype);
        ok       = m.hit && !mode_bad && !req_lock && !len_zero;
    end

endmodule

// File: rtl/owm_chunk_calc.sv
module owm_chunk_calc
    import owm_pkg::*;
#(
    parameter int LW = 13
) (
    input  logic [PAGE_BITS-1:0] addr_lo,
    input  logic [LW-1:0]        rem,
    input  logic [CLEN_W-1:0]    limit,
    output logic [CLEN_W-1:0]    chunk_len,
    output logic                 is_last
);

    localparam int MW = (LW > PAGE_BITS + 1) ? LW : PAGE_BITS + 1;

    logic [MW-1:0] rem_w, lim_w, dist_w, m1, m2;

    always_comb begin
        rem_w  = MW'(rem);
        lim_w  = MW'(limit);
        dist_w = MW'(13'(PAGE_BYTES) - {1'b0, addr_lo});
        m1     = (rem_w < lim_w) ? rem_w : lim_w;
        m2     = (m1 < dist_w) ? m1 : dist_w;
        chunk_len = CLEN_W'(m2);
        is_last   = (m2 == rem_w);
    end

endmodule

// File: rtl/owm_top.sv
module owm_top
    import owm_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 32,
    parameter int LW   = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rc_mode,
    input  logic [2:0]         mps_code,
    input  logic [2:0]         mrrs_code,
    input  logic [NWIN-1:0]    win_en,
    input  logic [NWIN*AW-1:0] win_base,
    input  logic [NWIN*AW-1:0] win_mask,
    input  logic [NWIN*AW-1:0] win_xlat,
    input  logic [2*NWIN-1:0]  win_type,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_lock,
    input  logic [AW-1:0]      req_addr,
    input  logic [LW-1:0]      req_len,
    output logic               err_valid,
    output logic               d_valid,
    input  logic               d_ready,
    output logic               d_write,
    output logic [1:0]         d_type,
    output logic [AW-1:0]      d_addr,
    output logic [8:0]         d_len,
    output logic               d_last
);

    match_t            mres;
    logic [AW-1:0]     xaddr;
    logic              ok;
    logic              acc;
    logic              busy;
    logic [AW-1:0]     cur_addr;
    logic [LW-1:0]     rem;
    logic              cur_write;
    tt_e               cur_type;
    logic              err_q;
    logic [CLEN_W-1:0] limit;
    logic [CLEN_W-1:0] chunk_len;
    logic              is_last;

    owm_win_match #(.NWIN(NWIN), .AW(AW)) u_match (
        .addr(req_addr), .win_en(win_en), .win_base(win_base),
        .win_mask(win_mask), .win_xlat(win_xlat), .win_type(win_type),
        .res(mres), .xaddr(xaddr)
    );

    owm_admit u_admit (
        .req_lock(req_lock), .len_zero(req_len == '0), .m(mres),
        .rc_mode(rc_mode), .ok(ok)
    );

    assign limit = cur_write ? lim_bytes(mps_code) : lim_bytes(mrrs_code);

    owm_chunk_calc #(.LW(LW)) u_chunk (
        .addr_lo(cur_addr[PAGE_BITS-1:0]), .rem(rem), .limit(limit),
        .chunk_len(chunk_len), .is_last(is_last)
    );

    assign req_ready = !busy;
    assign acc       = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cur_addr  <= '0;
            rem       <= '0;
            cur_write <= 1'b0;
            cur_type  <= TT_MEM;
            err_q     <= 1'b0;
        end else begin
            err_q <= acc && !ok;
            if (acc && ok) begin
                busy      <= 1'b1;
                cur_addr  <= xaddr;
                rem       <= req_len;
                cur_write <= req_write;
                cur_type  <= mres.ttype;
            end else if (busy && d_ready) begin
                cur_addr <= cur_addr + AW'(chunk_len);
                rem      <= rem - LW'(chunk_len);
                if (is_last) busy <= 1'b0;
            end
        end
    end

    assign err_valid = err_q;
    assign d_valid   = busy;
    assign d_write   = cur_write;
    assign d_type    = cur_type;
    assign d_addr    = cur_addr;
    assign d_len     = chunk_len;
    assign d_last    = busy && is_last;

    // R5 / R6: chunk within the 256-byte ceiling and non-empty
    p_len_cap_r5: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> (d_len != 9'd0) && (d_len <= 9'd256));
    p_dir_limit_r6: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_write |-> d_len <= lim_bytes(mrrs_code));
    // R7: no 4 KB crossing
    p_no_cross_r7: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> ({2'b00, d_addr[PAGE_BITS-1:0]} + 14'(d_len)) <= 14'd4096);
    // R9: no new request while descriptors are pending; held descriptor stable
    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !req_ready);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |=> d_valid && $stable(d_addr) && $stable(d_len));
    // R2: error response never overlaps descriptor output
    p_err_excl_r2: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !d_valid);
    // R3: endpoint mode never issues I/O or configuration descriptors
    p_ep_gate_r3: assert property (@(posedge clk) disable iff (rst)
        d_valid && !rc_mode && $stable(rc_mode) && $past(acc)
            |-> (d_type == 2'd0) || (d_type == 2'd2));
    // R4: locked request never starts descriptor output
    p_lock_r4: assert property (@(posedge clk) disable iff (rst)
        acc && req_lock |=> !d_valid && err_valid);

endmodule

// File: tb/tb_owm_top.sv
module tb_owm_top;

    localparam int NWIN = 4;
    localparam int AW   = 32;
    localparam int LW   = 13;

    logic               clk = 1'b0;
    logic               rst;
    logic               rc_mode;
    logic [2:0]         mps_code, mrrs_code;
    logic [NWIN-1:0]    win_en;
    logic [NWIN*AW-1:0] win_base, win_mask, win_xlat;
    logic [2*NWIN-1:0]  win_type;
    logic               req_valid, req_ready, req_write, req_lock;
    logic [AW-1:0]      req_addr;
    logic [LW-1:0]      req_len;
    logic               err_valid, d_valid, d_ready, d_write, d_last;
    logic [1:0]         d_type;
    logic [AW-1:0]      d_addr;
    logic [8:0]         d_len;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    owm_top #(.NWIN(NWIN), .AW(AW), .LW(LW)) dut (.*);

    task automatic chk(input logic cond, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic        lk;
        logic        rc;
        logic [31:0] addr;
        logic [12:0] len;
        logic        err;
        logic [7:0]  nch;
        logic [8:0]  flen;
        logic [1:0]  ty;
        logic [31:0] xa;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,32'h1000_0000,13'd256, 1'b0,8'd1, 9'd256,2'd0,32'h8000_0000},
        '{1'b1,1'b0,1'b1,32'h1000_0000,13'd600, 1'b0,8'd3, 9'd256,2'd0,32'h8000_0000},
        '{1'b0,1'b0,1'b1,32'h1000_0000,13'd300, 1'b0,8'd3, 9'd128,2'd0,32'h8000_0000},
        '{1'b1,1'b0,1'b1,32'h1000_0F80,13'd300, 1'b0,8'd2, 9'd128,2'd0,32'h8000_0F80},
        '{1'b0,1'b0,1'b1,32'h2000_0010,13'd4,   1'b0,8'd1, 9'd4,  2'd3,32'h0000_0010},
        '{1'b1,1'b0,1'b1,32'h2100_0000,13'd8,   1'b0,8'd1, 9'd8,  2'd1,32'h0100_0000},
        '{1'b1,1'b0,1'b1,32'h3000_0020,13'd64,  1'b0,8'd1, 9'd64, 2'd2,32'h4000_0020},
        '{1'b0,1'b0,1'b0,32'h2000_0010,13'd4,   1'b1,8'd0, 9'd0,  2'd0,32'h0},
        '{1'b1,1'b0,1'b0,32'h2100_0000,13'd8,   1'b1,8'd0, 9'd0,  2'd0,32'h0},
        '{1'b1,1'b0,1'b0,32'h3000_0000,13'd16,  1'b0,8'd1, 9'd16, 2'd2,32'h4000_0000},
        '{1'b1,1'b0,1'b0,32'h1000_0000,13'd200, 1'b0,8'd1, 9'd200,2'd0,32'h8000_0000},
        '{1'b1,1'b0,1'b1,32'h7000_0000,13'd16,  1'b1,8'd0, 9'd0,  2'd0,32'h0},
        '{1'b1,1'b1,1'b1,32'h1000_0000,13'd16,  1'b1,8'd0, 9'd0,  2'd0,32'h0},
        '{1'b1,1'b0,1'b1,32'h1000_0000,13'd0,   1'b1,8'd0, 9'd0,  2'd0,32'h0},
        '{1'b0,1'b0,1'b1,32'h1000_0FFF,13'd2,   1'b0,8'd2, 9'd1,  2'd0,32'h8000_0FFF},
        '{1'b1,1'b0,1'b1,32'h1000_0000,13'd4096,1'b0,8'd16,9'd256,2'd0,32'h8000_0000}
    };

    int          r_nch, r_err, r_flen, r_fty, r_sum;
    logic [31:0] r_fad;

    task automatic do_req(input logic wr, input logic lk, input logic rcm,
                          input logic [31:0] a, input logic [12:0] l);
        logic [31:0] nxt;
        int          lim;
        bit          done;
        lim = wr ? ((mps_code == 3'd0) ? 128 : 256) : ((mrrs_code == 3'd0) ? 128 : 256);
        @(negedge clk);
        rc_mode = rcm; req_write = wr; req_lock = lk; req_addr = a; req_len = l;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_nch = 0; r_err = 0; r_sum = 0; r_flen = 0; r_fty = 0; r_fad = '0;
        nxt = '0; done = 0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (err_valid) r_err++;
            if (d_valid) begin
                if (r_nch == 0) begin
                    r_flen = d_len; r_fty = d_type; r_fad = d_addr;
                end else begin
                    chk(d_addr == nxt, "R8 address continuity", d_addr, nxt);
                end
                chk(d_len <= lim && d_len != 0, wr ? "R5 write chunk limit" : "R6 read chunk limit", d_len, lim);
                chk(32'(d_addr[11:0]) + 32'(d_len) <= 4096, "R7 4KB crossing", d_addr[11:0] + d_len, 4096);
                chk(!req_ready, "R9 ready low while busy", req_ready, 0);
                r_sum += d_len;
                r_nch++;
                nxt = d_addr + 32'(d_len);
                if (d_last) begin
                    chk(r_sum == l, "R8 length sum", r_sum, l);
                    done = 1;
                end
            end
            if (done || (cyc >= 3 && r_nch == 0)) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rc_mode = 1'b1; mps_code = 3'd1; mrrs_code = 3'd0;
        req_valid = 0; req_write = 0; req_lock = 0; req_addr = '0; req_len = '0;
        d_ready = 1'b1;
        win_en = 4'b1111;
        win_base = '0; win_mask = '0; win_xlat = '0; win_type = '0;
        // W0 memory 0x1xxxxxxx -> 0x8xxxxxxx
        win_base[0*32 +: 32] = 32'h1000_0000; win_mask[0*32 +: 32] = 32'hF000_0000;
        win_xlat[0*32 +: 32] = 32'h8000_0000; win_type[0 +: 2] = 2'd0;
        // W1 configuration 0x2000xxxx (beats W2 on overlap)
        win_base[1*32 +: 32] = 32'h2000_0000; win_mask[1*32 +: 32] = 32'hFFFF_0000;
        win_xlat[1*32 +: 32] = 32'h0000_0000; win_type[2 +: 2] = 2'd3;
        // W2 I/O 0x2xxxxxxx
        win_base[2*32 +: 32] = 32'h2000_0000; win_mask[2*32 +: 32] = 32'hF000_0000;
        win_xlat[2*32 +: 32] = 32'h0000_0000; win_type[4 +: 2] = 2'd1;
        // W3 message 0x3xxxxxxx -> 0x4xxxxxxx
        win_base[3*32 +: 32] = 32'h3000_0000; win_mask[3*32 +: 32] = 32'hF000_0000;
        win_xlat[3*32 +: 32] = 32'h4000_0000; win_type[6 +: 2] = 2'd2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset req_ready", req_ready, 1);
        chk(d_valid == 1'b0, "R11 reset d_valid", d_valid, 0);
        chk(err_valid == 1'b0, "R11 reset err_valid", err_valid, 0);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R7 R8 R10 expectations
        for (int v = 0; v < NV; v++) begin
            do_req(VEC[v].wr, VEC[v].lk, VEC[v].rc, VEC[v].addr, VEC[v].len);
            if (VEC[v].err) begin
                chk(r_err == 1, "R2 R3 R4 R10 single error", r_err, 1);
                chk(r_nch == 0, "R2 R3 R4 R10 no descriptor", r_nch, 0);
            end else begin
                chk(r_err == 0, "R1 no error", r_err, 0);
                chk(r_nch == VEC[v].nch, "R8 chunk count", r_nch, VEC[v].nch);
                chk(r_flen == VEC[v].flen, "R7 first chunk length", r_flen, VEC[v].flen);
                chk(r_fty == VEC[v].ty, "R1 R3 type", r_fty, VEC[v].ty);
                chk(r_fad == VEC[v].xa, "R1 translated address", r_fad, VEC[v].xa);
            end
        end

        // R5: code 7 still capped at 256
        mps_code = 3'd7;
        do_req(1'b1, 1'b0, 1'b1, 32'h1000_0000, 13'd600);
        chk(r_flen == 256, "R5 cap at 256", r_flen, 256);
        chk(r_nch == 3, "R5 chunk count cap", r_nch, 3);
        // R5: code 0 gives 128
        mps_code = 3'd0;
        do_req(1'b1, 1'b0, 1'b1, 32'h1000_0000, 13'd300);
        chk(r_flen == 128 && r_nch == 3, "R5 write code 0", r_flen, 128);
        // R6: read code 3 gives 256
        mrrs_code = 3'd3;
        do_req(1'b0, 1'b0, 1'b1, 32'h1000_0000, 13'd300);
        chk(r_flen == 256 && r_nch == 2, "R6 read code 3", r_flen, 256);
        mps_code = 3'd1; mrrs_code = 3'd0;

        // R1: disabled window is skipped
        win_en[3] = 1'b0;
        do_req(1'b1, 1'b0, 1'b1, 32'h3000_0000, 13'd16);
        chk(r_err == 1 && r_nch == 0, "R1 disabled window", r_err, 1);
        win_en[3] = 1'b1;

        // R9: stall holds descriptor and blocks new requests
        @(negedge clk);
        d_ready = 1'b0;
        req_write = 1'b1; req_lock = 1'b0; rc_mode = 1'b1;
        req_addr = 32'h1000_0100; req_len = 13'd40; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h1000_0200; req_len = 13'd8;
        for (int k = 0; k < 4; k++) begin
            chk(d_valid && d_addr == 32'h8000_0100 && d_len == 40, "R9 held descriptor", d_addr, 32'h8000_0100);
            chk(!req_ready, "R9 ready low in stall", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        d_ready = 1'b1;
        chk(d_last == 1'b1, "R8 last on single chunk", d_last, 1);
        @(negedge clk);
        chk(!d_valid && req_ready, "R9 idle after last handoff", d_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule